// File: doc/BRIEF.md
# Prescaled Capture-Compare Timer

This block is an up-counting timer with a counter that is 32 bits wide by default. A count clock comes from one of two places: the block clock, or an external clock pin that is brought into the clock domain first. That clock goes through a programmable divider before it advances the counter. One compare register and one capture register sit beside the counter. The compare register can leave the counter running freely through the match, or it can send the counter back to zero so that it produces a periodic event. The capture register takes a snapshot of the counter when the capture pin shows the selected edge, either rising or falling.

Software uses a small word-wide register port: one write strobe, an address, write data and a combinational read-data bus. Three sticky event flags record compare matches, captures and counter wraps. Writing a one to a flag clears it. A single interrupt line is the OR of the flags whose enables are set.

Register map (address: content):
- 0 control: bit 0 run, bit 1 restart-on-compare mode, bit 2 external count source, bit 3 capture on falling edge, bit 4 compare interrupt enable, bit 5 capture interrupt enable, bit 6 wrap interrupt enable.
- 1 divider value (12 bits).
- 2 compare value.
- 3 captured value (read only).
- 4 flags: bit 0 compare, bit 1 capture, bit 2 wrap.
- 5 live count (read only).

Unmapped addresses read as zero.

Top module: `capcmp_timer`

## Requirements
- R1: After reset the count reads 0, the flags (address 4) read 0, irq is low, the control register reads 0 and the compare register reads all ones at the counter width.
- R2: With the internal source and divider value P, the counter advances once every P+1 clocks. The first advance comes P+1 clocks after the clock edge that captured the write setting control bit 0.
- R3: A new divider value written while the timer runs is used only after the current divider period ends. The period in progress completes with the old value.
- R4: With control bit 1 clear, the counter runs through the compare value. Flag bit 0 sets when the counter steps onto the compare value. When the counter steps from all ones to zero, flag bit 2 sets.
- R5: With control bit 1 set, the counter steps from the compare value to zero on the next advance. Flag bit 0 sets each time the counter steps onto the compare value, and that includes compare value 0.
- R6: While running with control bit 3 clear, a rising edge on cap_in loads the count into address 3 and sets flag bit 1. The value loaded is the count present two clock edges after the pin changed, and it is loaded on the third edge.
- R7: With control bit 3 set, only falling edges of cap_in capture. A rising edge leaves address 3 and flag bit 1 unchanged.
- R8: With control bit 2 set, each rising edge of ext_clk, after a two-stage synchroniser, is one divider input. Block clock cycles alone do not advance the counter.
- R9: Writing address 4 clears the flags written as one and leaves the flags written as zero.
- R10: irq is high exactly when some flag is set and its enable bit (control bits 4 to 6, same order as the flags) is set.
- R11: Clearing control bit 0 returns the count and the divider to zero one clock later. The flags and the captured value are kept.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| wr_en | input | 1 | Register write strobe |
| addr | input | 3 | Register address |
| wdata | input | 32 | Register write data |
| rdata | output | 32 | Register read data, combinational from addr |
| ext_clk | input | 1 | External count clock, asynchronous |
| cap_in | input | 1 | Capture trigger pin, asynchronous |
| irq | output | 1 | Interrupt request |

## Verification
The hardest case to reach from the ports is the wrap from all ones to zero. There is no way to load the counter, so the full 32-bit range would take billions of clocks. The bench therefore builds the block with a 12-bit counter, which the width parameter allows, runs it undivided, and samples one cycle before and one cycle after the wrap. Changing the divider in mid-period is the other delicate case. The write is timed to land two clocks into a divide-by-four period, so that a divider taking effect at once would give a different count from one taking effect at the rollover.

// File: rtl/capcmp_pkg.sv
package capcmp_pkg;
  localparam int ADDR_W = 3;
  localparam int DATA_W = 32;
  localparam int FLAG_W = 3;

  localparam logic [ADDR_W-1:0] A_CTRL  = 3'd0;
  localparam logic [ADDR_W-1:0] A_DIV   = 3'd1;
  localparam logic [ADDR_W-1:0] A_CMP   = 3'd2;
  localparam logic [ADDR_W-1:0] A_CAP   = 3'd3;
  localparam logic [ADDR_W-1:0] A_FLAGS = 3'd4;
  localparam logic [ADDR_W-1:0] A_COUNT = 3'd5;

  // bit 0 is run, bit 6 is the wrap interrupt enable
  typedef struct packed {
    logic ie_wrap;
    logic ie_cap;
    logic ie_cmp;
    logic cap_fall;
    logic ext_src;
    logic restart;
    logic run;
  } ctrl_t;

  localparam int CTRL_W = $bits(ctrl_t);

  // sticky flags: a new event wins over a clear in the same cycle
  function automatic logic [FLAG_W-1:0] flags_next(logic [FLAG_W-1:0] cur,
                                                   logic [FLAG_W-1:0] set,
                                                   logic [FLAG_W-1:0] clr);
    return (cur & ~clr) | set;
  endfunction
endpackage

// File: rtl/capcmp_sync_edge.sv
module capcmp_sync_edge #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic din,
  input  logic sel_fall,
  output logic edge_pulse
);
  logic [STAGES:0] shreg;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) shreg <= '0;
    else        shreg <= {shreg[STAGES-1:0], din};
  end

  logic now_v, prev_v;
  assign now_v  = shreg[STAGES-1];
  assign prev_v = shreg[STAGES];
  assign edge_pulse = sel_fall ? (prev_v & ~now_v) : (now_v & ~prev_v);
endmodule

// File: rtl/capcmp_prescaler.sv
module capcmp_prescaler #(
  parameter int PRE_W = 12
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             run,
  input  logic             src_pulse,
  input  logic [PRE_W-1:0] div_req,
  output logic             tick
);
  logic [PRE_W-1:0] pcnt, div_act;
  logic at_end;

  assign at_end = (pcnt == div_act);
  assign tick   = run & src_pulse & at_end;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pcnt    <= '0;
      div_act <= '0;
    end else if (!run) begin
      pcnt    <= '0;
      div_act <= div_req;
    end else if (src_pulse) begin
      if (at_end) begin
        pcnt    <= '0;
        div_act <= div_req;
      end else begin
        pcnt <= pcnt + PRE_W'(1);
      end
    end
  end
endmodule

// File: rtl/capcmp_counter.sv
module capcmp_counter #(
  parameter int CNT_W = 32
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             run,
  input  logic             tick,
  input  logic             restart,
  input  logic [CNT_W-1:0] cmp,
  output logic [CNT_W-1:0] cnt,
  output logic             cmp_hit,
  output logic             wrap_evt
);
  function automatic logic [CNT_W-1:0] step(logic [CNT_W-1:0] cur,
                                            logic [CNT_W-1:0] cmpv,
                                            logic             rs_mode);
    if (rs_mode && (cur == cmpv)) return '0;
    return cur + CNT_W'(1);
  endfunction

  logic [CNT_W-1:0] nxt;
  assign nxt      = step(cnt, cmp, restart);
  assign cmp_hit  = tick && (nxt == cmp);
  assign wrap_evt = tick && (cnt == '1);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)    cnt <= '0;
    else if (!run) cnt <= '0;
    else if (tick) cnt <= nxt;
  end
endmodule

// File: rtl/capcmp_timer.sv
module capcmp_timer
  import capcmp_pkg::*;
#(
  parameter int CNT_W       = 32,
  parameter int PRE_W       = 12,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DATA_W-1:0] wdata,
  output logic [DATA_W-1:0] rdata,
  input  logic              ext_clk,
  input  logic              cap_in,
  output logic              irq
);
  ctrl_t             ctrl_q;
  logic [PRE_W-1:0]  div_q;
  logic [CNT_W-1:0]  cmp_q, cap_q, cnt_w;
  logic [FLAG_W-1:0] flags_q;

  // named internal events
  logic run_w, restart_w, ext_edge_w, cap_edge_w, src_pulse_w, tick_w;
  logic cmp_hit_w, wrap_w, cap_evt_w;
  logic [FLAG_W-1:0] flag_set_w, flag_clr_w, ie_w;

  assign run_w     = ctrl_q.run;
  assign restart_w = ctrl_q.restart;

  capcmp_sync_edge #(.STAGES(SYNC_STAGES)) u_ext_sync (
    .clk(clk), .rst_n(rst_n), .din(ext_clk), .sel_fall(1'b0), .edge_pulse(ext_edge_w));

  capcmp_sync_edge #(.STAGES(SYNC_STAGES)) u_cap_sync (
    .clk(clk), .rst_n(rst_n), .din(cap_in), .sel_fall(ctrl_q.cap_fall), .edge_pulse(cap_edge_w));

  assign src_pulse_w = ctrl_q.ext_src ? ext_edge_w : 1'b1;

  capcmp_prescaler #(.PRE_W(PRE_W)) u_presc (
    .clk(clk), .rst_n(rst_n), .run(run_w), .src_pulse(src_pulse_w),
    .div_req(div_q), .tick(tick_w));

  capcmp_counter #(.CNT_W(CNT_W)) u_cnt (
    .clk(clk), .rst_n(rst_n), .run(run_w), .tick(tick_w), .restart(restart_w),
    .cmp(cmp_q), .cnt(cnt_w), .cmp_hit(cmp_hit_w), .wrap_evt(wrap_w));

  assign cap_evt_w  = run_w & cap_edge_w;
  assign flag_set_w = {wrap_w, cap_evt_w, cmp_hit_w};
  assign flag_clr_w = (wr_en && addr == A_FLAGS) ? wdata[FLAG_W-1:0] : '0;
  assign ie_w       = {ctrl_q.ie_wrap, ctrl_q.ie_cap, ctrl_q.ie_cmp};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ctrl_q <= '0;
      div_q  <= '0;
      cmp_q  <= '1;
    end else if (wr_en) begin
      case (addr)
        A_CTRL:  ctrl_q <= ctrl_t'(wdata[CTRL_W-1:0]);
        A_DIV:   div_q  <= wdata[PRE_W-1:0];
        A_CMP:   cmp_q  <= wdata[CNT_W-1:0];
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cap_q   <= '0;
      flags_q <= '0;
    end else begin
      if (cap_evt_w) cap_q <= cnt_w;
      flags_q <= flags_next(flags_q, flag_set_w, flag_clr_w);
    end
  end

  assign irq = |(flags_q & ie_w);

  always_comb begin
    rdata = '0;
    case (addr)
      A_CTRL:  rdata[CTRL_W-1:0] = ctrl_q;
      A_DIV:   rdata[PRE_W-1:0]  = div_q;
      A_CMP:   rdata[CNT_W-1:0]  = cmp_q;
      A_CAP:   rdata[CNT_W-1:0]  = cap_q;
      A_FLAGS: rdata[FLAG_W-1:0] = flags_q;
      A_COUNT: rdata[CNT_W-1:0]  = cnt_w;
      default: rdata = '0;
    endcase
  end
endmodule

// File: rtl/capcmp_timer_chk.sv
module capcmp_timer_chk #(
  parameter int CNT_W = 32
) (
  input logic             clk,
  input logic             rst_n,
  input logic             run,
  input logic             restart,
  input logic             tick,
  input logic [CNT_W-1:0] cnt,
  input logic [CNT_W-1:0] cmp,
  input logic             cap_evt,
  input logic [CNT_W-1:0] cap_q,
  input logic [2:0]       flags,
  input logic [2:0]       flag_clr
);
  // R11: a stopped timer holds a zero count
  p_stop_clears_r11: assert property (@(posedge clk) disable iff (!rst_n)
    !run |=> (cnt == '0));

  // R2: without a divider tick a running counter holds its value
  p_hold_between_ticks_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (run && !tick) |=> $stable(cnt));

  // R2: a tick away from compare-restart and wrap moves the count by one
  p_step_by_one_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (run && tick && !(restart && cnt == cmp) && cnt != '1) |=> (cnt == $past(cnt) + CNT_W'(1)));

  // R5: restart mode returns to zero from the compare value
  p_restart_zero_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (run && tick && restart && cnt == cmp) |=> (cnt == '0));

  // R6: a capture event latches the count
  p_capture_load_r6: assert property (@(posedge clk) disable iff (!rst_n)
    cap_evt |=> (cap_q == $past(cnt)));

  // R9: a flag not written with one stays set
  p_flag_sticky_r9: assert property (@(posedge clk) disable iff (!rst_n)
    ((flags & ~flag_clr) != 3'b000) |=> ((flags & $past(flags & ~flag_clr)) == $past(flags & ~flag_clr)));
endmodule

bind capcmp_timer capcmp_timer_chk #(.CNT_W(CNT_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .run(run_w), .restart(restart_w), .tick(tick_w),
  .cnt(cnt_w), .cmp(cmp_q), .cap_evt(cap_evt_w), .cap_q(cap_q),
  .flags(flags_q), .flag_clr(flag_clr_w));

// File: tb/capcmp_timer_bench.sv
module capcmp_timer_bench;
  localparam int CW = 12;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic wr_en = 1'b0;
  logic [2:0] addr = 3'd0;
  logic [31:0] wdata = 32'd0;
  logic [31:0] rdata;
  logic ext_clk = 1'b0;
  logic cap_in = 1'b0;
  logic irq;

  int checks = 0;
  int fails  = 0;
  logic [31:0] rv;

  always #5 clk = ~clk;

  capcmp_timer #(.CNT_W(CW)) u_capcmp_timer (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .addr(addr), .wdata(wdata),
    .rdata(rdata), .ext_clk(ext_clk), .cap_in(cap_in), .irq(irq));

  typedef struct packed {
    logic [11:0] div;
    logic [11:0] cmp;
    logic        restart;
    logic [15:0] n;
    logic [11:0] exp_cnt;
    logic        exp_flag;
  } vec_t;

  // wait n clocks after the enabling write, then expect count and compare flag
  localparam vec_t VECS [6] = '{
    '{12'd0, 12'd100, 1'b0, 16'd10, 12'd10, 1'b0},
    '{12'd3, 12'd5,   1'b0, 16'd40, 12'd10, 1'b1},
    '{12'd1, 12'd3,   1'b1, 16'd20, 12'd2,  1'b1},
    '{12'd0, 12'd0,   1'b1, 16'd5,  12'd0,  1'b1},
    '{12'd4, 12'd7,   1'b1, 16'd37, 12'd7,  1'b1},
    '{12'd9, 12'd2,   1'b0, 16'd19, 12'd1,  1'b0}
  };

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // write is captured at the posedge inside the task; returns just after it
  task automatic wr(input logic [2:0] a, input logic [31:0] d);
    @(negedge clk);
    wr_en = 1'b1; addr = a; wdata = d;
    @(posedge clk);
    #1 wr_en = 1'b0;
  endtask

  // combinational read at the current time
  task automatic rd(input logic [2:0] a, output logic [31:0] d);
    addr = a;
    #1 d = rdata;
  endtask

  task automatic finish_up;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    fails++;
    $display("FAIL watchdog expired");
    finish_up();
  end

  initial begin
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;

    // R1 reset state
    @(negedge clk);
    rd(3'd5, rv); check("R1 count", rv, 32'd0);
    rd(3'd4, rv); check("R1 flags", rv, 32'd0);
    rd(3'd2, rv); check("R1 compare", rv, 32'hFFF);
    rd(3'd0, rv); check("R1 control", rv, 32'd0);
    check("R1 irq", {31'd0, irq}, 32'd0);

    // R2 R4 R5 vector table
    foreach (VECS[i]) begin
      wr(3'd0, 32'd0);
      wr(3'd4, 32'd7);
      wr(3'd1, {20'd0, VECS[i].div});
      wr(3'd2, {20'd0, VECS[i].cmp});
      wr(3'd0, {30'd0, VECS[i].restart, 1'b1});
      repeat (int'(VECS[i].n)) @(posedge clk);
      @(negedge clk);
      rd(3'd5, rv); check("R2/R5 vector count", rv, {20'd0, VECS[i].exp_cnt});
      rd(3'd4, rv); check("R4/R5 vector compare flag", {31'd0, rv[0]}, {31'd0, VECS[i].exp_flag});
    end

    // R10 irq follows enabled flags (compare flag is set from last vector? use fresh)
    wr(3'd0, 32'd0);
    wr(3'd4, 32'd7);
    wr(3'd1, 32'd0);
    wr(3'd2, 32'd2);
    wr(3'd0, 32'd1);
    repeat (4) @(posedge clk);
    wr(3'd0, 32'h10);              // compare irq enable, stopped
    @(negedge clk);
    check("R10 irq with compare enable", {31'd0, irq}, 32'd1);
    wr(3'd0, 32'h20);              // only capture enable
    @(negedge clk);
    check("R10 irq masked", {31'd0, irq}, 32'd0);

    // R3 divider change mid-period
    wr(3'd4, 32'd7);
    wr(3'd1, 32'd3);
    wr(3'd2, 32'd100);
    wr(3'd0, 32'd1);
    repeat (1) @(posedge clk);
    wr(3'd1, 32'd0);
    repeat (4) @(posedge clk);
    @(negedge clk);
    rd(3'd5, rv); check("R3 divider change at rollover", rv, 32'd3);

    // R8 external clock source
    wr(3'd0, 32'd0);
    wr(3'd4, 32'd7);
    wr(3'd2, 32'hFFF);
    wr(3'd0, 32'd5);
    for (int k = 0; k < 5; k++) begin
      @(negedge clk); ext_clk = 1'b1;
      repeat (4) @(posedge clk);
      @(negedge clk); ext_clk = 1'b0;
      repeat (4) @(posedge clk);
    end
    repeat (6) @(posedge clk);
    @(negedge clk);
    rd(3'd5, rv); check("R8 external edges counted", rv, 32'd5);
    repeat (20) @(posedge clk);
    @(negedge clk);
    rd(3'd5, rv); check("R8 block clock ignored", rv, 32'd5);

    // R6 rising-edge capture
    wr(3'd0, 32'd0);
    wr(3'd4, 32'd7);
    wr(3'd0, 32'd1);
    repeat (4) @(posedge clk);
    @(negedge clk); cap_in = 1'b1;
    repeat (5) @(posedge clk);
    @(negedge clk);
    rd(3'd3, rv); check("R6 captured value", rv, 32'd6);
    rd(3'd4, rv); check("R6 capture flag", {31'd0, rv[1]}, 32'd1);

    // R7 falling-edge capture, rising ignored
    @(negedge clk); cap_in = 1'b0;
    repeat (5) @(posedge clk);
    wr(3'd0, 32'd0);
    wr(3'd4, 32'd7);
    wr(3'd0, 32'd9);
    repeat (3) @(posedge clk);
    @(negedge clk); cap_in = 1'b1;
    repeat (5) @(posedge clk);
    @(negedge clk);
    rd(3'd4, rv); check("R7 rising edge ignored flag", {31'd0, rv[1]}, 32'd0);
    rd(3'd3, rv); check("R7 rising edge ignored value", rv, 32'd6);
    repeat (2) @(posedge clk);
    @(negedge clk); cap_in = 1'b0;
    repeat (5) @(posedge clk);
    @(negedge clk);
    rd(3'd3, rv); check("R7 falling edge captured", rv, 32'd12);
    rd(3'd4, rv); check("R7 capture flag", {31'd0, rv[1]}, 32'd1);

    // R4 wrap from all ones
    wr(3'd0, 32'd0);
    wr(3'd4, 32'd7);
    wr(3'd1, 32'd0);
    wr(3'd2, 32'd100);
    wr(3'd0, 32'd1);
    repeat (4095) @(posedge clk);
    @(negedge clk);
    rd(3'd5, rv); check("R4 count at all ones", rv, 32'hFFF);
    rd(3'd4, rv); check("R4 no wrap yet", {31'd0, rv[2]}, 32'd0);
    @(posedge clk);
    @(negedge clk);
    rd(3'd5, rv); check("R4 count after wrap", rv, 32'd0);
    rd(3'd4, rv); check("R4 wrap flag", {31'd0, rv[2]}, 32'd1);

    // R11 stop clears the count, keeps flags
    wr(3'd0, 32'd0);
    @(posedge clk);
    @(negedge clk);
    rd(3'd5, rv); check("R11 count cleared", rv, 32'd0);
    rd(3'd4, rv); check("R11 flags kept", rv, 32'd5);

    // R9 write-one-to-clear
    wr(3'd4, 32'd1);
    @(negedge clk);
    rd(3'd4, rv); check("R9 clear compare only", rv, 32'd4);
    wr(3'd4, 32'd0);
    @(negedge clk);
    rd(3'd4, rv); check("R9 zero write no effect", rv, 32'd4);

    finish_up();
  end
endmodule